// File: doc/BRIEF.md
# Aliased Floating-Point Register Bank

This block holds sixty-four 32-bit single-precision registers in one flat array. Four access shapes reach that same storage. A scalar reaches one register. A double reaches an adjacent even/odd pair. A vector reaches four consecutive registers. A matrix reaches sixteen consecutive registers. The block does no arithmetic. It only moves words in and out, so an execution unit can load or store any of these shapes through one pair of ports.

There is one write port and one read port. Each port has a 2-bit shape code, a 6-bit index and a 512-bit data bus. The write port also has an enable. Writes take effect on the rising clock edge. Reads are combinational and show the array as it stood before the current edge. Any bus bits beyond the words that the chosen shape moves read as zero.

Shape codes are 0 for scalar, 1 for double, 2 for vector and 3 for matrix. A double must start on an even register. An odd starting index raises an error flag on the port that used it, and that access moves no data.

Top module: `fp_view_regfile`

## Requirements
- R1: After reset every register reads zero through every shape.
- R2: Shape 0 with index i reads or writes register i in bus bits 31:0. On a read, bus bits 511:32 are zero.
- R3: Shape 1 with even index i reads register i in bits 63:32 and register i+1 in bits 31:0. Bits 511:64 are zero.
- R4: A shape-1 write with even index i stores bus bits 63:32 into register i and bus bits 31:0 into register i+1.
- R5: Shape 1 with an odd index raises the error flag of that port. On the read port this gives an all-zero bus. On the write port, wr_err is high only while wr_en is high, and no register changes.
- R6: Shape 2 uses index bits 3:0 times 4 as its first register. It moves 4 consecutive registers, with the lowest-numbered register in bits 31:0. Read bits 511:128 are zero.
- R7: Shape 3 uses index bits 1:0 times 16 as its first register. It moves 16 consecutive registers, with the lowest-numbered register in bits 31:0.
- R8: While wr_en is low, no register changes.
- R9: A read in the same cycle as a write to the same registers returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| wr_en | input | 1 | Write enable |
| wr_view | input | 2 | Write shape code |
| wr_idx | input | 6 | Write index |
| wr_data | input | 512 | Write data; the lowest-numbered word sits in bits 31:0 |
| wr_err | output | 1 | Odd double index on an enabled write |
| rd_view | input | 2 | Read shape code |
| rd_idx | input | 6 | Read index |
| rd_data | output | 512 | Read data; unused upper bits are zero |
| rd_err | output | 1 | Odd double index on the read port |

## Verification
The bench builds the block at its default word width of 32. At that width the matrix shape fills the whole 512-bit bus, and every index bit takes part in some shape. This exposes index masking (vector indices of 16 and above, matrix indices of 4 and above), odd double indices and word ordering across the full bus. Random traffic often lands reads on the registers that the same cycle writes, which tests the rule that a read sees the value from before the write.

// File: rtl/fp_view_regfile.sv
module fp_view_regfile #(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_view,
  input  logic [5:0]      wr_idx,
  input  logic [16*W-1:0] wr_data,
  output logic            wr_err,
  input  logic [1:0]      rd_view,
  input  logic [5:0]      rd_idx,
  output logic [16*W-1:0] rd_data,
  output logic            rd_err
);
  localparam int NREG = 64;
  localparam logic [1:0] V_SCALAR = 2'd0;
  localparam logic [1:0] V_PAIR   = 2'd1;
  localparam logic [1:0] V_VEC    = 2'd2;
  localparam logic [1:0] V_MAT    = 2'd3;

  logic [NREG-1:0][W-1:0] regs;
  logic [NREG-1:0]        hit;
  logic [NREG-1:0][W-1:0] nxt;

  assign rd_err = (rd_view == V_PAIR) && rd_idx[0];
  assign wr_err = wr_en && (wr_view == V_PAIR) && wr_idx[0];

  always_comb begin
    rd_data = '0;
    case (rd_view)
      V_SCALAR: rd_data[W-1:0] = regs[rd_idx];
      V_PAIR:   if (!rd_idx[0]) rd_data[2*W-1:0] = {regs[rd_idx], regs[rd_idx | 6'd1]};
      V_VEC:    for (int k = 0; k < 4; k++) rd_data[k*W +: W] = regs[{rd_idx[3:0], 2'(k)}];
      default:  for (int k = 0; k < 16; k++) rd_data[k*W +: W] = regs[{rd_idx[1:0], 4'(k)}];
    endcase
  end

  always_comb begin
    for (int j = 0; j < NREG; j++) begin
      hit[j] = 1'b0;
      nxt[j] = wr_data[W-1:0];
      case (wr_view)
        V_SCALAR: hit[j] = (wr_idx == 6'(j));
        V_PAIR: if (!wr_idx[0]) begin
          if (wr_idx == 6'(j)) begin
            hit[j] = 1'b1;
            nxt[j] = wr_data[2*W-1:W];
          end else if ((wr_idx | 6'd1) == 6'(j)) begin
            hit[j] = 1'b1;
          end
        end
        V_VEC: begin
          hit[j] = (wr_idx[3:0] == 4'(j / 4));
          nxt[j] = wr_data[(j % 4)*W +: W];
        end
        default: begin
          hit[j] = (wr_idx[1:0] == 2'(j / 16));
          nxt[j] = wr_data[(j % 16)*W +: W];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs <= '0;
    else if (wr_en)
      for (int j = 0; j < NREG; j++)
        if (hit[j]) regs[j] <= nxt[j];
  end
endmodule

module fp_view_regfile_chk #(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [1:0]           wr_view,
  input logic [5:0]           wr_idx,
  input logic [16*W-1:0]      wr_data,
  input logic                 wr_err,
  input logic [1:0]           rd_view,
  input logic [5:0]           rd_idx,
  input logic [16*W-1:0]      rd_data,
  input logic [63:0][W-1:0]   regs
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(regs)); // R8
  AST_ODD_PAIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) wr_err |=> $stable(regs)); // R5
  AST_SCALAR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_view == 2'd0) |=> regs[$past(wr_idx)] == $past(wr_data[W-1:0])); // R2
  AST_PAIR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_view == 2'd1 && !wr_idx[0]) |=>
      (regs[$past(wr_idx)] == $past(wr_data[2*W-1:W]) &&
       regs[$past(wr_idx) + 6'd1] == $past(wr_data[W-1:0]))); // R4
  AST_SCALAR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_view == 2'd0 |-> rd_data[16*W-1:W] == '0); // R2
  AST_VEC_LOW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_view == 2'd2 |-> (rd_data[W-1:0] == regs[{rd_idx[3:0], 2'b00}] && rd_data[16*W-1:4*W] == '0)); // R6
endmodule

bind fp_view_regfile fp_view_regfile_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx),
  .wr_data(wr_data), .wr_err(wr_err), .rd_view(rd_view), .rd_idx(rd_idx),
  .rd_data(rd_data), .regs(regs)
);

// File: tb/test_fp_view_regfile.sv
`timescale 1ns/1ps
module test_fp_view_regfile;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wr_en, wr_err, rd_err;
  logic [1:0] wr_view, rd_view;
  logic [5:0] wr_idx, rd_idx;
  logic [511:0] wr_data, rd_data;

  fp_view_regfile i_fp_view_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_err(wr_err), .rd_view(rd_view), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_err(rd_err)
  );

  int n_vec = 0, n_bad = 0;
  logic [31:0] m [64];

  function automatic logic [511:0] model_rd(logic [1:0] v, logic [5:0] i);
    logic [511:0] r = '0;
    case (v)
      2'd0: r[31:0] = m[i];
      2'd1: if (!i[0]) r[63:0] = {m[i], m[i+1]};
      2'd2: for (int k = 0; k < 4; k++) r[k*32 +: 32] = m[int'(i[3:0])*4 + k];
      default: for (int k = 0; k < 16; k++) r[k*32 +: 32] = m[int'(i[1:0])*16 + k];
    endcase
    return r;
  endfunction

  task automatic model_wr(logic [1:0] v, logic [5:0] i, logic [511:0] d);
    case (v)
      2'd0: m[i] = d[31:0];
      2'd1: if (!i[0]) begin m[i] = d[63:32]; m[i+1] = d[31:0]; end
      2'd2: for (int k = 0; k < 4; k++) m[int'(i[3:0])*4 + k] = d[k*32 +: 32];
      default: for (int k = 0; k < 16; k++) m[int'(i[1:0])*16 + k] = d[k*32 +: 32];
    endcase
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int k = 0; k < 16; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic we, logic [1:0] wv, logic [5:0] wi, logic [511:0] wd,
                      logic [1:0] rv, logic [5:0] ri, string tag);
    string req;
    @(negedge clk);
    wr_en = we; wr_view = wv; wr_idx = wi; wr_data = wd;
    rd_view = rv; rd_idx = ri;
    #1;
    if (tag != "") req = tag;
    else req = (rv == 2'd0) ? "R2" : (rv == 2'd1) ? (ri[0] ? "R5" : "R3") : (rv == 2'd2) ? "R6" : "R7";
    chk(req, rd_data, model_rd(rv, ri));
    chk("R5", {511'd0, rd_err}, {511'd0, rv == 2'd1 && ri[0]});
    chk("R5", {511'd0, wr_err}, {511'd0, we && wv == 2'd1 && wi[0]});
    @(posedge clk);
    if (we) model_wr(wv, wi, wd);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) m[i] = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_view = '0; wr_idx = '0; wr_data = '0;
    rd_view = '0; rd_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 64; i++) step(1'b0, 2'd0, 6'd0, '0, 2'd0, 6'(i), "R1");
    for (int i = 0; i < 4; i++) step(1'b0, 2'd0, 6'd0, '0, 2'd3, 6'(i), "R1");

    step(1'b1, 2'd1, 6'd10, {448'd0, 64'hAAAA_BBBB_CCCC_DDDD}, 2'd0, 6'd0, "R4");
    step(1'b0, 2'd0, 6'd0, '0, 2'd0, 6'd10, "R4");
    step(1'b0, 2'd0, 6'd0, '0, 2'd0, 6'd11, "R4");
    step(1'b0, 2'd0, 6'd0, '0, 2'd1, 6'd10, "R3");

    step(1'b1, 2'd1, 6'd7, rnd512(), 2'd0, 6'd7, "R5");
    step(1'b0, 2'd0, 6'd0, '0, 2'd0, 6'd7, "R5");
    step(1'b0, 2'd0, 6'd0, '0, 2'd0, 6'd8, "R5");
    step(1'b0, 2'd0, 6'd0, '0, 2'd1, 6'd7, "R5");

    step(1'b0, 2'd0, 6'd5, rnd512(), 2'd0, 6'd5, "R8");
    step(1'b0, 2'd3, 6'd1, rnd512(), 2'd3, 6'd1, "R8");

    step(1'b1, 2'd2, 6'd53, rnd512(), 2'd2, 6'd5, "R6");
    step(1'b0, 2'd0, 6'd0, '0, 2'd2, 6'd5, "R6");
    step(1'b1, 2'd3, 6'd37, rnd512(), 2'd3, 6'd1, "R7");
    step(1'b0, 2'd0, 6'd0, '0, 2'd3, 6'd1, "R7");

    step(1'b1, 2'd3, 6'd2, rnd512(), 2'd3, 6'd2, "R9");
    step(1'b1, 2'd0, 6'd33, rnd512(), 2'd0, 6'd33, "R9");
    step(1'b0, 2'd0, 6'd0, '0, 2'd0, 6'd33, "R2");

    for (int n = 0; n < 3000; n++) begin
      logic [5:0] wi = 6'($urandom);
      logic [5:0] ri = ($urandom % 4 == 0) ? wi : 6'($urandom);
      step(($urandom % 4) != 0, 2'($urandom), wi, rnd512(), 2'($urandom), ri, "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule